// File: doc/BRIEF.md
# Wrapper Response Word Packer

This block sits at the response side of a core test wrapper that moves test data over an ordinary functional data port instead of a dedicated test bus. Each of the WC wrapper chains shifts one response bit per scan cycle out of its far end. The block gathers these serial bits and packs them into wide words for the data lines of the functional port. Command wires carry no test data. Stimulus loading runs at the same time on a separate port and is not part of this block.

The end of each chain feeds a small bank of parallel-unload cells, one per bit of the word period. The period is P = floor(W_OUT / WC). After P scan cycles the banks of all chains together form one response word, so the port carries one word every P cycles. Word bits that no chain covers are driven to zero. The first word of each pattern is different. A capture pulse loads the captured core outputs straight into the output slot across the full word width, and collection of the next word starts from phase zero. If the downstream port has not taken the previous word when a new word is ready, the block holds the chain shift enable low until the port takes it.

Top module: `rsp_word_unloader`

## Requirements
- R1: After reset, rsp_valid is 0 and rsp_data is 0. shift_en is 0 while test_en is 0.
- R2: The period is P = floor(W_OUT/WC). While the port keeps accepting, a new word becomes valid on the cycle after every P-th enabled shift cycle and at no other time.
- R3: Chain k fills word bits k*P through k*P+P-1. The bit sampled on the earliest shift cycle of the period sits in the lowest of these positions.
- R4: In a word built from shifted bits, every bit at or above WC*P is 0.
- R5: While cap_load is 1, shift_en is 0. On the next cycle rsp_valid is 1 and rsp_data equals cap_data on all W_OUT bits, spare bits included. Word collection then restarts at phase 0, and bits collected before the capture are discarded.
- R6: A word is ready to complete while the previous word is still valid and rsp_ready is 0. In that case shift_en is 0, and chain_so is ignored until the port takes the previous word.
- R7: While rsp_valid is 1 and rsp_ready is 0, rsp_valid stays 1 and rsp_data stays stable unless cap_load is applied.
- R8: While test_en is 0, shift_en is 0. No bit is collected, the phase holds, and no word is produced. Collection resumes where it stopped.

Ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan and port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Enables response unloading |
| cap_load | input | 1 | Loads the captured core outputs as the first word of a pattern |
| cap_data | input | W_OUT | Captured core output values |
| chain_so | input | WC | Serial output bit of each wrapper chain |
| shift_en | output | 1 | Shift clock enable for the wrapper chains |
| rsp_valid | output | 1 | Data-group valid of the functional port |
| rsp_ready | input | 1 | Data-group accept of the functional port |
| rsp_data | output | W_OUT | Response word on the port data lines |

## Verification
The embedded properties check, on every cycle, several behaviours. The phase stays inside the period and freezes whenever no shift or capture happens. A completed period always yields a valid word with zeroed spare bits. A pending word stays stable until it is accepted. A capture always puts cap_data in the slot. The bench scenarios are needed for the rest: the exact placement of each chain's bits within the word, the once-per-period word rate, the held word surviving a stall with chain_so changing, and phase restart after a capture that lands mid-word. The expected words come from the bit-placement rule rather than from the design.

// File: rtl/rwu_pkg.sv
package rwu_pkg;

  // Action taken on the response slot in a given cycle
  typedef enum logic [1:0] {
    SLOT_HOLD = 2'd0,
    SLOT_WORD = 2'd1,
    SLOT_CAPT = 2'd2
  } slot_act_e;

  // Word period from port width and chain count
  function automatic int period_of(input int w, input int c);
    return w / c;
  endfunction

  // Width of a counter that counts 0 .. p-1
  function automatic int ctr_width(input int p);
    return (p > 1) ? $clog2(p) : 1;
  endfunction

endpackage

// File: rtl/rwu_phase_ctr.sv
module rwu_phase_ctr #(
  parameter int P  = 3,
  parameter int CW = rwu_pkg::ctr_width(P)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          restart,
  output logic [CW-1:0] phase,
  output logic          last
);

  logic [CW-1:0] phase_n;

  assign last = (phase == CW'(P - 1));

  always_comb begin
    phase_n = phase;
    if (restart) begin
      phase_n = '0;
    end else if (step) begin
      phase_n = last ? '0 : phase + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else begin
      phase <= phase_n;
    end
  end

  // R2: phase never leaves the period
  a_r2_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= CW'(P - 1));

  // R8: with neither shift nor capture the phase is frozen
  a_r8_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !restart) |=> $stable(phase));

endmodule

// File: rtl/rwu_chain_lane.sv
module rwu_chain_lane #(
  parameter int P  = 3,
  parameter int CW = rwu_pkg::ctr_width(P),
  parameter int LW = P - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift,
  input  logic [CW-1:0] pos,
  input  logic          bit_in,
  output logic [LW-1:0] held
);

  logic [LW-1:0] held_n;

  // Earlier bits of the period are parked here. The final bit of the
  // period is used straight from the chain by the packer.
  always_comb begin
    held_n = held;
    if (shift) begin
      for (int i = 0; i < LW; i++) begin
        if (pos == CW'(i)) held_n[i] = bit_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
    end else begin
      held <= held_n;
    end
  end

endmodule

// File: rtl/rwu_word_pack.sv
module rwu_word_pack #(
  parameter int W_OUT = 32,
  parameter int WC    = 10,
  parameter int P     = rwu_pkg::period_of(W_OUT, WC),
  parameter int LW    = P - 1,
  parameter int USED  = WC * P
) (
  input  logic [WC*LW-1:0] held_flat,
  input  logic [WC-1:0]    live,
  output logic [W_OUT-1:0] word
);

  for (genvar k = 0; k < WC; k++) begin : g_lane
    assign word[k*P +: LW] = held_flat[k*LW +: LW];
    assign word[k*P + LW]  = live[k];
  end

  if (USED < W_OUT) begin : g_spare
    assign word[W_OUT-1:USED] = '0;
  end

endmodule

// File: rtl/rwu_out_slot.sv
module rwu_out_slot #(
  parameter int W_OUT = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  rwu_pkg::slot_act_e  act,
  input  logic [W_OUT-1:0]    word_in,
  input  logic [W_OUT-1:0]    cap_in,
  input  logic                rsp_ready,
  output logic                rsp_valid,
  output logic [W_OUT-1:0]    rsp_data
);

  import rwu_pkg::*;

  logic             valid_n;
  logic [W_OUT-1:0] data_n;
  logic             data_en;

  always_comb begin
    valid_n = rsp_valid & ~rsp_ready;
    data_n  = rsp_data;
    data_en = 1'b0;
    unique case (act)
      SLOT_WORD: begin
        valid_n = 1'b1;
        data_n  = word_in;
        data_en = 1'b1;
      end
      SLOT_CAPT: begin
        valid_n = 1'b1;
        data_n  = cap_in;
        data_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= valid_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data <= '0;
    end else if (data_en) begin
      rsp_data <= data_n;
    end
  end

  // R7: an unaccepted word stays put
  a_r7_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready && act == SLOT_HOLD) |=> (rsp_valid && $stable(rsp_data)));

  // R5: a capture lands in the slot on the full width
  a_r5_capture_word: assert property (@(posedge clk) disable iff (!rst_n)
    (act == SLOT_CAPT) |=> (rsp_valid && rsp_data == $past(cap_in)));

endmodule

// File: rtl/rsp_word_unloader.sv
module rsp_word_unloader #(
  parameter int W_OUT = 32,
  parameter int WC    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_en,
  input  logic             cap_load,
  input  logic [W_OUT-1:0] cap_data,
  input  logic [WC-1:0]    chain_so,
  output logic             shift_en,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [W_OUT-1:0] rsp_data
);

  import rwu_pkg::*;

  // P must be at least 2 (W_OUT >= 2*WC)
  localparam int P    = period_of(W_OUT, WC);
  localparam int CW   = ctr_width(P);
  localparam int LW   = P - 1;
  localparam int USED = WC * P;

  logic [CW-1:0]    phase;
  logic             phase_last;
  logic             stall;
  logic [WC*LW-1:0] held_flat;
  logic [W_OUT-1:0] packed_word;
  slot_act_e        act;

  // A completed word waits for a free slot; the chains wait with it
  assign stall    = phase_last & rsp_valid & ~rsp_ready;
  assign shift_en = test_en & ~cap_load & ~stall;

  always_comb begin
    act = SLOT_HOLD;
    if (cap_load) begin
      act = SLOT_CAPT;
    end else if (shift_en && phase_last) begin
      act = SLOT_WORD;
    end
  end

  rwu_phase_ctr #(.P(P), .CW(CW)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (shift_en),
    .restart (cap_load),
    .phase   (phase),
    .last    (phase_last)
  );

  for (genvar k = 0; k < WC; k++) begin : g_chain
    rwu_chain_lane #(.P(P), .CW(CW), .LW(LW)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .shift  (shift_en),
      .pos    (phase),
      .bit_in (chain_so[k]),
      .held   (held_flat[k*LW +: LW])
    );
  end

  rwu_word_pack #(.W_OUT(W_OUT), .WC(WC), .P(P), .LW(LW), .USED(USED)) u_pack (
    .held_flat (held_flat),
    .live      (chain_so),
    .word      (packed_word)
  );

  rwu_out_slot #(.W_OUT(W_OUT)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (act),
    .word_in   (packed_word),
    .cap_in    (cap_data),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  // R2: finishing a period always presents a word
  a_r2_word_out: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && phase_last) |=> rsp_valid);

  if (USED < W_OUT) begin : g_spare_chk
    // R4: uncovered word bits are zero in shifted words
    a_r4_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && phase_last) |=> (rsp_data[W_OUT-1:USED] == '0));
  end

endmodule

// File: tb/rsp_word_unloader_tb.sv
module rsp_word_unloader_tb;

  localparam int W  = 8;
  localparam int NC = 3;   // period 2, spare bits [7:6]

  logic          clk = 1'b0;
  logic          rst_n;
  logic          test_en;
  logic          cap_load;
  logic [W-1:0]  cap_data;
  logic [NC-1:0] chain_so;
  logic          shift_en;
  logic          rsp_valid;
  logic          rsp_ready;
  logic [W-1:0]  rsp_data;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rsp_word_unloader #(.W_OUT(W), .WC(NC)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_en   (test_en),
    .cap_load  (cap_load),
    .cap_data  (cap_data),
    .chain_so  (chain_so),
    .shift_en  (shift_en),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data)
  );

  // {first-cycle bits, second-cycle bits, expected word}
  localparam logic [13:0] VEC [6] = '{
    {3'b001, 3'b000, 8'h01},
    {3'b000, 3'b001, 8'h02},
    {3'b100, 3'b000, 8'h10},
    {3'b111, 3'b111, 8'h3F},
    {3'b010, 3'b100, 8'h24},
    {3'b101, 3'b010, 8'h19}
  };

  task automatic chk(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    n_run++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; test_en = 1'b0; cap_load = 1'b0; cap_data = '0;
    chain_so = '0; rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid", 32'(rsp_valid), 32'd0);
    chk("R1 data", 32'(rsp_data), 32'd0);
    chk("R1 shift_en", 32'(shift_en), 32'd0);

    test_en = 1'b1; rsp_ready = 1'b1;
    for (int i = 0; i < 6; i++) begin
      chain_so = VEC[i][13:11];
      @(negedge clk);
      if (i > 0) chk("R2 no word mid-period", 32'(rsp_valid), 32'd0);
      chain_so = VEC[i][10:8];
      @(negedge clk);
      chk("R2 word valid", 32'(rsp_valid), 32'd1);
      if (i == 3) chk("R4 spare bits zero", 32'(rsp_data), 32'(VEC[i][7:0]));
      else        chk("R3 bit placement", 32'(rsp_data), 32'(VEC[i][7:0]));
    end

    // R6/R7: stall with a pending word (0x19) not accepted
    rsp_ready = 1'b0;
    chain_so = 3'b010;
    @(negedge clk);
    chain_so = 3'b100;
    #1 chk("R6 shift held", 32'(shift_en), 32'd0);
    chk("R7 data held", 32'(rsp_data), 32'h19);
    chain_so = 3'b111;
    @(negedge clk);
    chk("R7 valid held", 32'(rsp_valid), 32'd1);
    chk("R7 data still held", 32'(rsp_data), 32'h19);
    chk("R6 still held", 32'(shift_en), 32'd0);
    chain_so = 3'b100; rsp_ready = 1'b1;
    #1 chk("R6 released", 32'(shift_en), 32'd1);
    @(negedge clk);
    chk("R6 word after stall", 32'(rsp_data), 32'h24);

    // R8: test_en low pauses collection mid-word
    chain_so = 3'b101;
    @(negedge clk);
    test_en = 1'b0; chain_so = 3'b111;
    #1 chk("R8 shift off", 32'(shift_en), 32'd0);
    @(negedge clk);
    chk("R8 no word", 32'(rsp_valid), 32'd0);
    chain_so = 3'b000;
    @(negedge clk);
    test_en = 1'b1; chain_so = 3'b010;
    @(negedge clk);
    chk("R8 resumed word", 32'(rsp_data), 32'h19);

    // R5: capture lands mid-word, restarts phase
    chain_so = 3'b111;
    @(negedge clk);
    cap_load = 1'b1; cap_data = 8'hC5;
    #1 chk("R5 shift off in capture", 32'(shift_en), 32'd0);
    @(negedge clk);
    cap_load = 1'b0;
    chk("R5 capture valid", 32'(rsp_valid), 32'd1);
    chk("R5 capture data", 32'(rsp_data), 32'hC5);
    chain_so = 3'b000;
    @(negedge clk);
    chain_so = 3'b001;
    @(negedge clk);
    chk("R5 phase restart", 32'(rsp_data), 32'h02);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule